// File: doc/BRIEF.md
# Output-Port Contention Concentrator

This block settles output contention for a single output of an N-port cell switch. Every input of the switch drives a broadcast bus into it, made of a valid flag, a one-bit priority, an N-bit destination bitmap and a payload word. The block keeps only the cells that are valid and whose bitmap has the bit of this output set. From those candidates it selects at most L winners. The winners are packed onto L output lanes that feed the output buffer, and the block returns one grant bit per input. The input side samples the grant bits to decide which cells it keeps and sends again in a later switch cycle.

Selection is purely combinational from the current bus contents. A high-priority candidate always beats a low-priority one. Among candidates of equal priority, the one closest to the rotation origin wins. The origin is a register that moves forward by one input at the end of every switch cycle. In the default build this spreads the lowest-index advantage evenly over all inputs. A build parameter can pin the origin at input 0, which gives plain lowest-index-first order.

Top module: `cell_concentrator`

## Requirements
- R1: Input j is a candidate only when `in_valid[j]` is 1 and bit `j*N_PORTS+OUT_IDX` of `in_dest` is 1. Bit `j*N_PORTS+k` of `in_dest` marks output k for input j. A cell that is invalid, or that is addressed only to other outputs, is never granted.
- R2: At most N_LANES candidates are granted. When there are more candidates than that, exactly N_LANES are granted and the rest see a grant bit of 0.
- R3: With the origin at 0 (after reset), candidates of equal priority win in ascending input index.
- R4: A candidate with `in_prio` = 1 (high) always wins over a candidate with `in_prio` = 0 (low), whatever their input indices.
- R5: The k winners sit on lanes 0 to k-1 in arbitration order. That order is all high-priority winners first, then the low-priority winners, and inside each class the order runs upward from the origin with wrap-around. Lane m carries the winner's input index on `lane_src[m*IDXW +: IDXW]` and its payload on `lane_data`. Unused lanes have `lane_valid` 0 and zero index and payload.
- R6: The grant and lane outputs follow the current inputs in the same cycle, with no clock edge in between.
- R7: Each clock edge with `cycle_end` = 1 moves the origin up by one and wraps from N_PORTS-1 to 0. Edges with `cycle_end` = 0 leave it unchanged. While the origin is at input o, the equal-priority order is o, o+1, … with wrap-around.
- R8: While `rst_n` is low the origin is 0. With no candidates, no grant or lane valid is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cycle_end | input | 1 | Last clock of a switch cycle; advances the origin |
| in_valid | input | N_PORTS | Per-input bus valid |
| in_prio | input | N_PORTS | Per-input priority, 1 = high |
| in_dest | input | N_PORTS*N_PORTS | Destination bitmaps, input j at bits j*N_PORTS +: N_PORTS |
| in_data | input | N_PORTS*DATA_W | Payloads, input j at bits j*DATA_W +: DATA_W |
| grant | output | N_PORTS | Per-input win at this output |
| lane_valid | output | N_LANES | Lane occupied |
| lane_src | output | N_LANES*IDXW | Winning input index per lane |
| lane_data | output | N_LANES*DATA_W | Winning payload per lane |

## Verification
The selector is driven with several patterns, and each one isolates a single decision. Cells addressed only to other outputs, and invalid cells with the right bit, show whether the filter works separately from selection. A fully loaded low-priority set shows the cap of L winners and the lowest-index rule. A mix where the high-priority cells sit on the highest inputs separates class ordering from index ordering. A sparse set shows lane packing and how empty lanes are cleared. The origin is then stepped to a middle value and to a value near the top. In the second case equal-priority winners wrap past the last input, which a design without rotation, or one that rotates the wrong way, would get wrong.

// File: rtl/cc_pkg.sv
package cc_pkg;
  // Add two port indices modulo the port count.
  function automatic int wrap_idx(input int a, input int b, input int n);
    int s;
    s = a + b;
    if (s >= n) s = s - n;
    return s;
  endfunction
endpackage

// File: rtl/cc_filter.sv
module cc_filter #(
  parameter int N_PORTS = 8,
  parameter int OUT_IDX = 0
) (
  input  logic [N_PORTS-1:0]         in_valid,
  input  logic [N_PORTS*N_PORTS-1:0] in_dest,
  output logic [N_PORTS-1:0]         cand
);
  for (genvar j = 0; j < N_PORTS; j++) begin : g_cand
    assign cand[j] = in_valid[j] & in_dest[j*N_PORTS + OUT_IDX];
  end
endmodule

// File: rtl/cc_rotor.sv
module cc_rotor #(
  parameter int N_PORTS = 8,
  parameter bit ROTATE  = 1'b1,
  localparam int IDXW   = (N_PORTS > 1) ? $clog2(N_PORTS) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cycle_end,
  output logic [IDXW-1:0] origin
);
  if (ROTATE) begin : g_rot
    logic [IDXW-1:0] org_q, org_d;
    logic            org_en;

    assign org_en = cycle_end;

    always_comb begin
      if (org_q == IDXW'(N_PORTS-1)) org_d = '0;
      else                           org_d = org_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      org_q <= '0;
      else if (org_en) org_q <= org_d;
    end

    assign origin = org_q;

    assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !cycle_end |=> $stable(origin));
    assert_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (cycle_end && origin == IDXW'(N_PORTS-1)) |=> (origin == '0));
    assert_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
      int'(origin) < N_PORTS);
  end else begin : g_fixed
    assign origin = '0;
  end
endmodule

// File: rtl/cc_select.sv
module cc_select
  import cc_pkg::*;
#(
  parameter int N_PORTS = 8,
  parameter int N_LANES = 3,
  parameter int DATA_W  = 16,
  localparam int IDXW   = (N_PORTS > 1) ? $clog2(N_PORTS) : 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [N_PORTS-1:0]        cand,
  input  logic [N_PORTS-1:0]        in_prio,
  input  logic [N_PORTS*DATA_W-1:0] in_data,
  input  logic [IDXW-1:0]           origin,
  output logic [N_PORTS-1:0]        grant,
  output logic [N_LANES-1:0]        lane_valid,
  output logic [N_LANES*IDXW-1:0]   lane_src,
  output logic [N_LANES*DATA_W-1:0] lane_data
);
  always_comb begin
    int cnt;
    int idx;
    grant      = '0;
    lane_valid = '0;
    lane_src   = '0;
    lane_data  = '0;
    cnt        = 0;
    // Pass 0 takes high priority, pass 1 takes low priority.
    for (int pass = 0; pass < 2; pass++) begin
      for (int p = 0; p < N_PORTS; p++) begin
        idx = wrap_idx(p, int'(origin), N_PORTS);
        if (cand[idx] && (in_prio[idx] == (pass == 0)) && cnt < N_LANES) begin
          grant[idx]                     = 1'b1;
          lane_valid[cnt]                = 1'b1;
          lane_src[cnt*IDXW +: IDXW]     = IDXW'(idx);
          lane_data[cnt*DATA_W +: DATA_W] = in_data[idx*DATA_W +: DATA_W];
          cnt = cnt + 1;
        end
      end
    end
  end

  assert_cap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(grant) <= N_LANES);
  assert_full_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(cand) >= N_LANES) |-> ($countones(grant) == N_LANES));
  assert_cand_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (grant & ~cand) == '0);
  assert_class_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (|(cand & in_prio & ~grant)) |-> ((grant & ~in_prio) == '0));
  assert_count_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(lane_valid) == $countones(grant));

  for (genvar k = 0; k + 1 < N_LANES; k++) begin : g_pack
    assert_packed_R5: assert property (@(posedge clk) disable iff (!rst_n)
      lane_valid[k+1] |-> lane_valid[k]);
  end
endmodule

// File: rtl/cell_concentrator.sv
module cell_concentrator #(
  parameter int N_PORTS = 8,
  parameter int N_LANES = 3,
  parameter int OUT_IDX = 2,
  parameter int DATA_W  = 16,
  parameter bit ROTATE  = 1'b1,
  localparam int IDXW   = (N_PORTS > 1) ? $clog2(N_PORTS) : 1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        cycle_end,
  input  logic [N_PORTS-1:0]          in_valid,
  input  logic [N_PORTS-1:0]          in_prio,
  input  logic [N_PORTS*N_PORTS-1:0]  in_dest,
  input  logic [N_PORTS*DATA_W-1:0]   in_data,
  output logic [N_PORTS-1:0]          grant,
  output logic [N_LANES-1:0]          lane_valid,
  output logic [N_LANES*IDXW-1:0]     lane_src,
  output logic [N_LANES*DATA_W-1:0]   lane_data
);
  logic [N_PORTS-1:0] cand;
  logic [IDXW-1:0]    origin;

  cc_filter #(.N_PORTS(N_PORTS), .OUT_IDX(OUT_IDX)) u_filter (
    .in_valid(in_valid), .in_dest(in_dest), .cand(cand));

  cc_rotor #(.N_PORTS(N_PORTS), .ROTATE(ROTATE)) u_rotor (
    .clk(clk), .rst_n(rst_n), .cycle_end(cycle_end), .origin(origin));

  cc_select #(.N_PORTS(N_PORTS), .N_LANES(N_LANES), .DATA_W(DATA_W)) u_select (
    .clk(clk), .rst_n(rst_n), .cand(cand), .in_prio(in_prio),
    .in_data(in_data), .origin(origin), .grant(grant),
    .lane_valid(lane_valid), .lane_src(lane_src), .lane_data(lane_data));

  assert_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid == '0) |-> (grant == '0 && lane_valid == '0));
endmodule

// File: tb/tb_cell_concentrator.sv
module tb_cell_concentrator;
  localparam int N = 8;
  localparam int L = 3;
  localparam int OI = 2;
  localparam int DW = 16;
  localparam int IW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cycle_end = 1'b0;
  logic [N-1:0] in_valid = '0;
  logic [N-1:0] in_prio = '0;
  logic [N*N-1:0] in_dest = '0;
  logic [N*DW-1:0] in_data = '0;
  logic [N-1:0] grant;
  logic [L-1:0] lane_valid;
  logic [L*IW-1:0] lane_src;
  logic [L*DW-1:0] lane_data;

  int checks = 0;
  int errors = 0;
  int org = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  cell_concentrator #(.N_PORTS(N), .N_LANES(L), .OUT_IDX(OI), .DATA_W(DW)) dut (
    .clk(clk), .rst_n(rst_n), .cycle_end(cycle_end), .in_valid(in_valid),
    .in_prio(in_prio), .in_dest(in_dest), .in_data(in_data), .grant(grant),
    .lane_valid(lane_valid), .lane_src(lane_src), .lane_data(lane_data));

  task automatic expect_eq(input string req, input string what,
                           input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // hit: bitmap bit for this output; other: bits for other outputs only.
  task automatic drive(input logic [N-1:0] v, input logic [N-1:0] pr,
                       input logic [N-1:0] hit, input logic [N-1:0] other);
    for (int j = 0; j < N; j++) begin
      logic [N-1:0] d;
      d = '0;
      if (other[j]) d = 8'h81 << (j % 2);
      d[OI] = hit[j];
      in_dest[j*N +: N] = d;
      in_data[j*DW +: DW] = 16'hA000 + 16'(j * 16'h0111);
    end
    in_valid = v;
    in_prio = pr;
  endtask

  // Independent expectation from R1..R7, compared at the ports.
  task automatic check_model(input string req, input logic [N-1:0] v,
                             input logic [N-1:0] pr, input logic [N-1:0] hit);
    logic [N-1:0] eg;
    logic [L-1:0] ev;
    logic [L*IW-1:0] es;
    logic [L*DW-1:0] ed;
    int n;
    eg = '0; ev = '0; es = '0; ed = '0; n = 0;
    for (int cls = 1; cls >= 0; cls--)
      for (int p = 0; p < N; p++) begin
        int j;
        j = (p + org) % N;
        if (v[j] && hit[j] && pr[j] == cls[0] && n < L) begin
          eg[j] = 1'b1; ev[n] = 1'b1;
          es[n*IW +: IW] = IW'(j);
          ed[n*DW +: DW] = 16'hA000 + 16'(j * 16'h0111);
          n++;
        end
      end
    #1;
    expect_eq(req, "grant", 64'(grant), 64'(eg));
    expect_eq(req, "lane_valid", 64'(lane_valid), 64'(ev));
    expect_eq(req, "lane_src", 64'(lane_src), 64'(es));
    expect_eq(req, "lane_data", 64'(lane_data), 64'(ed));
  endtask

  task automatic apply(input string req, input logic [N-1:0] v,
                       input logic [N-1:0] pr, input logic [N-1:0] hit,
                       input logic [N-1:0] other);
    @(negedge clk);
    drive(v, pr, hit, other);
    check_model(req, v, pr, hit);
  endtask

  task automatic step_origin(input int k);
    for (int i = 0; i < k; i++) begin
      @(negedge clk);
      cycle_end = 1'b1;
      @(negedge clk);
      cycle_end = 1'b0;
      org = (org + 1) % N;
    end
  endtask

  task automatic t_reset_R8();
    @(negedge clk);
    drive('0, '0, '0, '0);
    #1;
    expect_eq("R8", "grant idle", 64'(grant), 64'h0);
    expect_eq("R8", "lanes idle", 64'(lane_valid), 64'h0);
  endtask

  task automatic t_filter_R1();
    apply("R1", 8'hFF, 8'h00, 8'h00, 8'hFF);
    apply("R1", 8'h00, 8'h00, 8'hFF, 8'h00);
    apply("R1", 8'h5A, 8'h00, 8'hF0, 8'hFF);
  endtask

  task automatic t_cap_R2_R3();
    apply("R2", 8'hFF, 8'h00, 8'hFF, 8'h00);
    expect_eq("R3", "lowest three", 64'(grant), 64'h07);
  endtask

  task automatic t_prio_R4();
    apply("R4", 8'hFF, 8'hC0, 8'hFF, 8'h00);
    expect_eq("R4", "high first", 64'(grant), 64'hC1);
    expect_eq("R4", "lane0 src", 64'(lane_src[IW-1:0]), 64'd6);
  endtask

  task automatic t_pack_R5();
    apply("R5", 8'h28, 8'h20, 8'h28, 8'h00);
    expect_eq("R5", "lane0 high src", 64'(lane_src[IW-1:0]), 64'd5);
    expect_eq("R5", "lane2 empty", 64'(lane_valid[2]), 64'd0);
  endtask

  task automatic t_comb_R6();
    @(negedge clk);
    drive(8'h10, 8'h00, 8'h10, 8'h00);
    #0.5;
    expect_eq("R6", "same cycle grant", 64'(grant), 64'h10);
    drive(8'h90, 8'h80, 8'h90, 8'h00);
    #0.5;
    expect_eq("R6", "retracked grant", 64'(grant), 64'h90);
    expect_eq("R6", "lane0 src", 64'(lane_src[IW-1:0]), 64'd7);
  endtask

  task automatic t_rotate_R7();
    step_origin(3);
    apply("R7", 8'hFF, 8'h00, 8'hFF, 8'h00);
    expect_eq("R7", "origin 3", 64'(grant), 64'h38);
    step_origin(3);
    apply("R7", 8'hFF, 8'h00, 8'hFF, 8'h00);
    expect_eq("R7", "origin 6 wrap", 64'(grant), 64'hC1);
    apply("R7", 8'hFF, 8'h02, 8'hFF, 8'h00);
    step_origin(2);
    apply("R7", 8'hFF, 8'h00, 8'hFF, 8'h00);
    expect_eq("R7", "origin back to 0", 64'(grant), 64'h07);
    @(negedge clk);
    @(negedge clk);
    check_model("R7", 8'hFF, 8'h00, 8'hFF);
  endtask

  initial begin
    #12;
    t_reset_R8();
    @(negedge clk);
    rst_n = 1'b1;
    t_reset_R8();
    t_filter_R1();
    t_cap_R2_R3();
    t_prio_R4();
    t_pack_R5();
    t_comb_R6();
    t_rotate_R7();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule